// File: doc/BRIEF.md
# Flash Command Dispatcher with Holding Slot

This block sits between a host-facing register window and a set of per-bank flash sequencers. The host writes a command's fields into staging registers: target bank, opcode, row address, column address and option bits. It then writes the issue register. On the next clock the dispatcher decides what to do with the command. If the target bank's sequencer is idle, the command is launched straight into that bank. If the bank is busy, the command is copied into a single shared holding slot. If the slot is already occupied, the command is dropped.

A parked command is handed to its bank as soon as that bank reports that its next state is idle. The slot is then free again. The host is expected to poll the slot-busy status bit before issuing. A monitor flag reports whether any work is outstanding. It rises whenever a command is accepted, and it falls only when every bank is idle and the slot is empty. The sequencers themselves, data movement and the flash pins are outside this block.

Top module: `flash_cmd_dispatch`

## Requirements
- R1: An issued command whose target bank reports idle, and which is not taken over by a slot release, raises that bank's launch strobe. The strobe appears in the cycle after the issue-register write. The launched command carries the staged fields, packed as opcode in bits [3:0], row in [19:4], column in [31:20] and option in [35:32].
- R2: An issued command whose target bank is not idle is stored in the holding slot when the slot is free. The slot-busy bit (status register bit 0) then reads 1.
- R3: An issue that arrives while the slot is occupied and not being released in the same cycle is ignored. Nothing is launched and the parked command stays unchanged.
- R4: Writing any value to the issue register sets a pending bit, which reads back in bit 0 of that register. The bit clears at the clock edge that processes the command, whether the command was launched, parked or ignored.
- R5: While the slot is busy and its bank signals next-idle, the parked command is launched to that bank in that cycle, and the slot-busy bit returns to 0.
- R6: When a slot release and a new issue fall in the same cycle, the release is handled first. The new issue then sees a free slot. If it targets the bank being released, it is parked rather than launched.
- R7: The monitor flag (status bit 1) is set by every accepted command, whether launched or parked. It is cleared only when all banks report idle and the slot is empty.
- R8: Writes to the staging registers after a command has been parked do not alter the fields that the slot later launches.
- R9: After reset the slot is empty, the monitor flag and the issue-pending bit are 0, and no launch strobe is raised.
- R10: The register map places opcode at address 0, bank at 1, row at 2, column at 3, option at 4, issue at 5 and status at 6. Each field is right-aligned and extra write bits are discarded. Status is read-only, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Register write strobe |
| host_wr_addr | input | 3 | Register write address |
| host_wr_data | input | 32 | Register write data |
| host_rd_addr | input | 3 | Register read address |
| host_rd_data | output | 32 | Register read data (combinational) |
| bank_idle | input | NUM_BANKS | Per-bank sequencer is idle now |
| bank_next_idle | input | NUM_BANKS | Per-bank sequencer will be idle after this cycle |
| launch_vld | output | NUM_BANKS | Per-bank command start strobe |
| launch_cmd | output | NUM_BANKS*36 | Per-bank packed command, bank b at [b*36 +: 36] |

## Verification
An issue written at edge k is processed in the cycle that follows. Any launch strobe and launched fields are combinational in that cycle, between edge k and edge k+1. The slot-busy bit, the monitor flag and the cleared issue-pending bit become readable only after edge k+1. The bench keeps a cycle-level model of the staging registers, the slot, the flag and its own bank counters. It drives its inputs on the falling edge and compares the launch outputs and the register read in the same half-cycle. It commits its model state just after the following rising edge, so every comparison lines up with the register stage that produces it. The bank counters make next-idle coincide with new issues often, which exercises simultaneous release and issue.

// File: rtl/flash_disp_pkg.sv
package flash_disp_pkg;

    localparam int OPC_W  = 4;
    localparam int ROW_W  = 16;
    localparam int COL_W  = 12;
    localparam int OPT_W  = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int CMD_W  = OPC_W + ROW_W + COL_W + OPT_W;

    typedef struct packed {
        logic [OPT_W-1:0] opt;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic [OPC_W-1:0] opc;
    } fcmd_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_OPC   = 3'd0,
        RA_BANK  = 3'd1,
        RA_ROW   = 3'd2,
        RA_COL   = 3'd3,
        RA_OPT   = 3'd4,
        RA_ISSUE = 3'd5,
        RA_STAT  = 3'd6,
        RA_NONE  = 3'd7
    } reg_addr_e;

    function automatic int unsigned bank_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/flash_disp_regs.sv
module flash_disp_regs
    import flash_disp_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  slot_busy,
    input  logic                  mon_flag,
    output fcmd_t                 stage_cmd,
    output logic [BANK_W-1:0]     stage_bank,
    output logic                  issue_pend
);

    fcmd_t             cmd_q;
    logic [BANK_W-1:0] bank_q;
    logic              issue_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            bank_q  <= '0;
            issue_q <= 1'b0;
        end else begin
            // a pending issue is consumed every cycle it is seen
            issue_q <= wr_en && (reg_addr_e'(wr_addr) == RA_ISSUE);
            if (wr_en) begin
                case (reg_addr_e'(wr_addr))
                    RA_OPC:  cmd_q.opc <= wr_data[OPC_W-1:0];
                    RA_BANK: bank_q    <= wr_data[BANK_W-1:0];
                    RA_ROW:  cmd_q.row <= wr_data[ROW_W-1:0];
                    RA_COL:  cmd_q.col <= wr_data[COL_W-1:0];
                    RA_OPT:  cmd_q.opt <= wr_data[OPT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            RA_OPC:   rd_data[OPC_W-1:0]  = cmd_q.opc;
            RA_BANK:  rd_data[BANK_W-1:0] = bank_q;
            RA_ROW:   rd_data[ROW_W-1:0]  = cmd_q.row;
            RA_COL:   rd_data[COL_W-1:0]  = cmd_q.col;
            RA_OPT:   rd_data[OPT_W-1:0]  = cmd_q.opt;
            RA_ISSUE: rd_data[0]          = issue_q;
            RA_STAT:  rd_data[1:0]        = {mon_flag, slot_busy};
            default:  rd_data             = '0;
        endcase
    end

    assign stage_cmd  = cmd_q;
    assign stage_bank = bank_q;
    assign issue_pend = issue_q;

endmodule

// File: rtl/flash_disp_route.sv
module flash_disp_route
    import flash_disp_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic                        issue,
    input  fcmd_t                       stage_cmd,
    input  logic [BANK_W-1:0]           stage_bank,
    input  logic                        slot_busy,
    input  logic [BANK_W-1:0]           slot_bank,
    input  fcmd_t                       slot_cmd,
    input  logic [NUM_BANKS-1:0]        bank_idle,
    input  logic [NUM_BANKS-1:0]        bank_next_idle,
    output logic                        slot_release,
    output logic                        park,
    output logic                        accept,
    output logic [NUM_BANKS-1:0]        launch_vld,
    output logic [NUM_BANKS*CMD_W-1:0]  launch_cmd
);

    logic slot_free;
    logic tgt_blocked;
    logic direct;

    // the parked command is resolved before the new issue is evaluated
    assign slot_release = slot_busy && bank_next_idle[slot_bank];
    assign slot_free    = !slot_busy || slot_release;
    assign tgt_blocked  = !bank_idle[stage_bank] ||
                          (slot_release && (slot_bank == stage_bank));
    assign direct       = issue && slot_free && !tgt_blocked;
    assign park         = issue && slot_free && tgt_blocked;
    assign accept       = direct || park;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic from_slot;
        logic from_host;
        assign from_slot = slot_release && (slot_bank == BANK_W'(b));
        assign from_host = direct && (stage_bank == BANK_W'(b));
        assign launch_vld[b] = from_slot || from_host;
        assign launch_cmd[b*CMD_W +: CMD_W] = from_slot ? slot_cmd : stage_cmd;
    end

endmodule

// File: rtl/flash_disp_slot.sv
module flash_disp_slot
    import flash_disp_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              park,
    input  logic              release_now,
    input  fcmd_t             in_cmd,
    input  logic [BANK_W-1:0] in_bank,
    output logic              busy,
    output logic [BANK_W-1:0] bank,
    output fcmd_t             cmd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            bank <= '0;
            cmd  <= '0;
        end else if (park) begin
            // whole command captured in one edge
            busy <= 1'b1;
            bank <= in_bank;
            cmd  <= in_cmd;
        end else if (release_now) begin
            busy <= 1'b0;
        end
    end

endmodule

// File: rtl/flash_disp_mon.sv
module flash_disp_mon #(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  logic                 slot_busy,
    input  logic [NUM_BANKS-1:0] bank_idle,
    output logic                 flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (accept) begin
            flag <= 1'b1;
        end else if ((&bank_idle) && !slot_busy) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/flash_cmd_dispatch.sv
module flash_cmd_dispatch
    import flash_disp_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       host_wr_en,
    input  logic [2:0]                 host_wr_addr,
    input  logic [31:0]                host_wr_data,
    input  logic [2:0]                 host_rd_addr,
    output logic [31:0]                host_rd_data,
    input  logic [NUM_BANKS-1:0]       bank_idle,
    input  logic [NUM_BANKS-1:0]       bank_next_idle,
    output logic [NUM_BANKS-1:0]       launch_vld,
    output logic [NUM_BANKS*36-1:0]    launch_cmd
);

    localparam int BANK_W = bank_bits(NUM_BANKS);

    fcmd_t             stage_cmd;
    logic [BANK_W-1:0] stage_bank;
    logic              issue_q;
    logic              slot_busy;
    logic [BANK_W-1:0] slot_bank;
    fcmd_t             slot_cmd;
    logic              slot_release;
    logic              park;
    logic              accept;
    logic              mon_flag;

    flash_disp_regs #(.BANK_W(BANK_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (host_wr_en),
        .wr_addr    (host_wr_addr),
        .wr_data    (host_wr_data),
        .rd_addr    (host_rd_addr),
        .rd_data    (host_rd_data),
        .slot_busy  (slot_busy),
        .mon_flag   (mon_flag),
        .stage_cmd  (stage_cmd),
        .stage_bank (stage_bank),
        .issue_pend (issue_q)
    );

    flash_disp_route #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) route_i (
        .issue          (issue_q),
        .stage_cmd      (stage_cmd),
        .stage_bank     (stage_bank),
        .slot_busy      (slot_busy),
        .slot_bank      (slot_bank),
        .slot_cmd       (slot_cmd),
        .bank_idle      (bank_idle),
        .bank_next_idle (bank_next_idle),
        .slot_release   (slot_release),
        .park           (park),
        .accept         (accept),
        .launch_vld     (launch_vld),
        .launch_cmd     (launch_cmd)
    );

    flash_disp_slot #(.BANK_W(BANK_W)) slot_i (
        .clk         (clk),
        .rst         (rst),
        .park        (park),
        .release_now (slot_release),
        .in_cmd      (stage_cmd),
        .in_bank     (stage_bank),
        .busy        (slot_busy),
        .bank        (slot_bank),
        .cmd         (slot_cmd)
    );

    flash_disp_mon #(.NUM_BANKS(NUM_BANKS)) mon_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .slot_busy (slot_busy),
        .bank_idle (bank_idle),
        .flag      (mon_flag)
    );

endmodule

// File: rtl/flash_disp_chk.sv
module flash_disp_chk #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 issue_q,
    input logic                 host_wr_en,
    input logic [2:0]           host_wr_addr,
    input logic                 slot_busy,
    input logic [BANK_W-1:0]    slot_bank,
    input logic [BANK_W-1:0]    stage_bank,
    input logic [NUM_BANKS-1:0] bank_idle,
    input logic [NUM_BANKS-1:0] bank_next_idle,
    input logic [NUM_BANKS-1:0] launch_vld,
    input logic                 mon_flag
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
        // R1: a bank is only started when it is idle or about to be
        a_r1_launch_ready: assert property (@(posedge clk) disable iff (rst)
            launch_vld[b] |-> (bank_idle[b] || bank_next_idle[b]));
    end

    // R6: at most one release and one direct launch per cycle
    a_r6_two_launches_max: assert property (@(posedge clk) disable iff (rst)
        $countones(launch_vld) <= 2);

    // R2: busy target with free slot parks the command
    a_r2_park_busy: assert property (@(posedge clk) disable iff (rst)
        (issue_q && !slot_busy && !bank_idle[stage_bank])
        |=> (slot_busy && slot_bank == $past(stage_bank)));

    // R3: occupied slot not releasing keeps its content
    a_r3_full_holds: assert property (@(posedge clk) disable iff (rst)
        (slot_busy && !bank_next_idle[slot_bank])
        |=> (slot_busy && $stable(slot_bank)));

    // R4: pending issue clears after being processed
    a_r4_issue_clears: assert property (@(posedge clk) disable iff (rst)
        (issue_q && !(host_wr_en && host_wr_addr == 3'd5)) |=> !issue_q);

    // R5: release frees the slot when no issue competes
    a_r5_release_frees: assert property (@(posedge clk) disable iff (rst)
        (slot_busy && bank_next_idle[slot_bank] && !issue_q) |=> !slot_busy);

    // R7: any launch leaves the monitor flag set
    a_r7_flag_on_launch: assert property (@(posedge clk) disable iff (rst)
        (|launch_vld) |=> mon_flag);

endmodule

bind flash_cmd_dispatch flash_disp_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .issue_q        (issue_q),
    .host_wr_en     (host_wr_en),
    .host_wr_addr   (host_wr_addr),
    .slot_busy      (slot_busy),
    .slot_bank      (slot_bank),
    .stage_bank     (stage_bank),
    .bank_idle      (bank_idle),
    .bank_next_idle (bank_next_idle),
    .launch_vld     (launch_vld),
    .mon_flag       (mon_flag)
);

// File: tb/flash_cmd_dispatch_tb.sv
`timescale 1ns/1ps
module flash_cmd_dispatch_tb_top;

    localparam int NB   = 4;
    localparam int CW   = 36;
    localparam int NCYC = 4000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [2:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NB-1:0] b_idle;
    logic [NB-1:0] b_nidle;
    logic [NB-1:0] launch_vld;
    logic [NB*CW-1:0] launch_cmd;

    always #4 clk = ~clk;

    flash_cmd_dispatch #(.NUM_BANKS(NB)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .host_wr_en     (wr_en),
        .host_wr_addr   (wr_addr),
        .host_wr_data   (wr_data),
        .host_rd_addr   (rd_addr),
        .host_rd_data   (rd_data),
        .bank_idle      (b_idle),
        .bank_next_idle (b_nidle),
        .launch_vld     (launch_vld),
        .launch_cmd     (launch_cmd)
    );

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;
    logic [31:0] seed   = 32'h1234_5678;

    // bench-owned bank sequencer model
    int cnt   [NB];
    int n_cnt [NB];

    // reference state
    logic [3:0]  m_opc, n_opc;
    logic [1:0]  m_bank, n_bank;
    logic [15:0] m_row, n_row;
    logic [11:0] m_col, n_col;
    logic [3:0]  m_opt, n_opt;
    logic        m_issue, n_issue;
    logic        s_busy, n_sbusy;
    logic [1:0]  s_bank, n_sbank;
    logic [35:0] s_cmd, n_scmd;
    logic        m_flag, n_flag;

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            b_idle[b]  = (cnt[b] == 0);
            b_nidle[b] = (cnt[b] <= 1);
        end
    end

    function automatic logic [31:0] lcg(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return {28'd0, m_opc};
            3'd1: return {30'd0, m_bank};
            3'd2: return {16'd0, m_row};
            3'd3: return {20'd0, m_col};
            3'd4: return {28'd0, m_opt};
            3'd5: return {31'd0, m_issue};
            3'd6: return {30'd0, m_flag, s_busy};
            default: return 32'd0;
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) cnt[b] = 0;
        m_opc = '0; m_bank = '0; m_row = '0; m_col = '0; m_opt = '0;
        m_issue = 1'b0; s_busy = 1'b0; s_bank = '0; s_cmd = '0; m_flag = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R9: reset state seen at the ports
        @(negedge clk);
        rd_addr = 3'd6; #1;
        check("R9 status", rd_data, 0);
        check("R9 launch", launch_vld, 0);
        @(negedge clk);
        rd_addr = 3'd5; #1;
        check("R9 issue", rd_data, 0);

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            logic [31:0] r;
            logic [31:0] d;
            logic        rel;
            logic        freed;
            logic        blocked;
            logic        direct;
            logic        park;
            logic [35:0] stg;
            @(negedge clk);
            seed = lcg(seed); r = seed;
            seed = lcg(seed); d = seed;
            wr_en   = r[16] | r[17];
            wr_addr = (r[20:18] < 3'd3) ? 3'd5 : r[26:24];
            wr_data = d;
            rd_addr = r[30:28];
            #1;
            stg     = {m_opt, m_col, m_row, m_opc};
            rel     = s_busy && (cnt[s_bank] <= 1);
            freed   = !s_busy || rel;
            blocked = (cnt[m_bank] != 0) || (rel && s_bank == m_bank);
            direct  = m_issue && freed && !blocked;
            park    = m_issue && freed && blocked;

            for (int b = 0; b < NB; b++) begin
                logic ev;
                logic [35:0] ec;
                string tag;
                ev = 1'b0; ec = stg; tag = "R1";
                if (rel && s_bank == 2'(b)) begin
                    ev = 1'b1; ec = s_cmd;
                    tag = (s_cmd != stg) ? "R8 slot fields" : (m_issue ? "R6 release+issue" : "R5 release");
                end else if (direct && m_bank == 2'(b)) begin
                    ev = 1'b1; tag = "R1 direct";
                end else if (m_issue && !freed) begin
                    tag = "R3 ignored";
                end else if (park && m_bank == 2'(b)) begin
                    tag = "R2 parked";
                end
                check(tag, launch_vld[b], ev);
                if (ev) check(tag, launch_cmd[b*CW +: CW], ec);
            end
            if (rd_addr == 3'd5)      check("R4 issue bit", rd_data, exp_read(rd_addr));
            else if (rd_addr == 3'd6) check("R2/R7 status", rd_data, exp_read(rd_addr));
            else                      check("R10 field read", rd_data, exp_read(rd_addr));

            // next reference state
            for (int b = 0; b < NB; b++) begin
                if ((rel && s_bank == 2'(b)) || (direct && m_bank == 2'(b)))
                    n_cnt[b] = ((rel && s_bank == 2'(b)) ? int'(s_cmd[2:0]) : int'(m_opc[2:0])) + 1;
                else
                    n_cnt[b] = (cnt[b] > 0) ? cnt[b] - 1 : 0;
            end
            n_sbusy = park ? 1'b1 : (rel ? 1'b0 : s_busy);
            n_sbank = park ? m_bank : s_bank;
            n_scmd  = park ? stg : s_cmd;
            if (direct || park) n_flag = 1'b1;
            else if ((cnt[0] == 0) && (cnt[1] == 0) && (cnt[2] == 0) && (cnt[3] == 0) && !s_busy) n_flag = 1'b0;
            else n_flag = m_flag;
            n_issue = wr_en && (wr_addr == 3'd5);
            n_opc = m_opc; n_bank = m_bank; n_row = m_row; n_col = m_col; n_opt = m_opt;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: n_opc  = wr_data[3:0];
                    3'd1: n_bank = wr_data[1:0];
                    3'd2: n_row  = wr_data[15:0];
                    3'd3: n_col  = wr_data[11:0];
                    3'd4: n_opt  = wr_data[3:0];
                    default: ;
                endcase
            end

            @(posedge clk);
            #1;
            for (int b = 0; b < NB; b++) cnt[b] = n_cnt[b];
            s_busy = n_sbusy; s_bank = n_sbank; s_cmd = n_scmd; m_flag = n_flag;
            m_issue = n_issue;
            m_opc = n_opc; m_bank = n_bank; m_row = n_row; m_col = n_col; m_opt = n_opt;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule